// File: doc/BRIEF.md
# JTAG Test Access Port with Mixed-Kind Boundary Scan

This block is a test access port controller clocked by the test clock. It holds a 4-bit instruction register, a 32-bit identification register, a 3-bit general test register, a 1-bit bypass register and a boundary scan chain. A 16-state controller, stepped by the test mode select input, decides when the selected register captures, shifts and updates.

The boundary chain sits between the core and the pads. Each pad is one of four kinds: input-only, output-only, tristate output or bidirectional. The parameter `PAD_KINDS` sets the kind of each pad, and each kind gets a cell with as many scan bits as it has fields. In functional mode the core drives the pads. A sample instruction reads the live pad and core values and preloads the hold stage while the pads stay untouched. The external-test instruction drives pad values and enables from the hold stage.

All pins are plain control and serial pins. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `jtag_bscan_tap`

## Requirements
- R1: The controller follows the standard 16-state sequence. After five rising TCK edges with TMS high, the state is Test-Logic-Reset. From a Shift or Pause state, TMS 1, 1, 0 on successive edges passes through Update and ends in Run-Test/Idle.
- R2: While trst_n is low, the controller is in Test-Logic-Reset, the instruction is IDCODE, TDO is not driven and every pad is in functional mode.
- R3: Instruction codes are: 0 = external test, 1 = IDCODE, 2 = sample/preload, 4 = test register, any other code = bypass. Capture-IR loads 0b0001 into the instruction shift stage, which shifts out LSB first. Update-IR makes the shifted code active.
- R4: Under IDCODE, Capture-DR loads 0x000018FF, which shifts out LSB first.
- R5: Under bypass, Capture-DR loads 0 into a 1-bit register, so TDO repeats TDI one shift later.
- R6: The test register is 3 bits. Capture leaves it unchanged, so a scan returns the bits shifted in by the previous scan.
- R7: Cell lengths by kind: input 1 bit, output 1 bit, tristate 2 bits (value, enable), bidirectional 3 bits (input, value, enable). Pads are chained in index order from the TDI end, with fields in that order. With the default kinds (pad 0 input, pad 1 output, pad 2 tristate, pad 3 bidirectional), the 7-bit word shifted LSB first has these bits: bit 6 = pad_i[0], bit 5 = core_o[1], bit 4 = core_o[2], bit 3 = core_oe[2], bit 2 = pad_i[3], bit 1 = core_o[3], bit 0 = core_oe[3].
- R8: Under sample/preload and under external test, Capture-DR loads the live pad inputs and the core value and enable into the chain.
- R9: Outside external test, the core drives the pads. pad_o and pad_oe follow core_o and core_oe, an output-only pad has its enable held at 1, and an input-only pad has pad_o = 0 and pad_oe = 0. A preload through Update-DR leaves the pads unchanged.
- R10: Under external test, pad values and enables come from the hold stage that the last Update-DR loaded, and changes on the core side have no effect on the pads.
- R11: TDO and tdo_oe change only on the falling edge of TCK. tdo_oe is 1 only while the controller is in Shift-IR or Shift-DR.
- R12: core_i follows pad_i for input-only and bidirectional pads in every mode, and is 0 for the other kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | TDO drive enable |
| core_o | input | NUM_PADS | Output value from the core, one bit per pad |
| core_oe | input | NUM_PADS | Output enable from the core, one bit per pad |
| core_i | output | NUM_PADS | Input value delivered to the core |
| pad_i | input | NUM_PADS | Value received at the pad |
| pad_o | output | NUM_PADS | Value driven onto the pad |
| pad_oe | output | NUM_PADS | Pad drive enable |

## Verification
The bench uses the default parameters: four pads, one of each kind, a 7-bit chain, the 0x18FF identification value and a 3-bit test register. With these values every cell length and every field position of R7 appears in one scan word, so a misplaced or missing field shows up as a wrong captured bit or a wrong pad drive. Using both bypass codes and reaching Update through a Pause state also exercises the instruction decode and the less common controller paths.

// File: rtl/jtag_bscan_pkg.sv
package jtag_bscan_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_e;

  localparam int          OP_W       = 4;
  localparam logic [3:0]  OP_EXTEST  = 4'd0;
  localparam logic [3:0]  OP_IDCODE  = 4'd1;
  localparam logic [3:0]  OP_SAMPLE  = 4'd2;
  localparam logic [3:0]  OP_TESTREG = 4'd4;
  localparam logic [3:0]  IR_CAPTURE = 4'b0001;

  // pad kind codes used in PAD_KINDS
  localparam int PK_IN    = 0;
  localparam int PK_OUT   = 1;
  localparam int PK_TRI   = 2;
  localparam int PK_BIDIR = 3;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    case (s)
      TS_RESET:    n = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     n = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   n = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   n = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: n = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: n = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: n = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: n = tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   n = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   n = tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   n = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: n = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: n = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: n = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: n = tms ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   n = tms ? TS_SEL_DR   : TS_IDLE;
      default:     n = TS_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_bscan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= tap_next(state, tms);
  end

  // consecutive TMS-high counter, saturating at five, used by the check below
  logic [2:0] ones_cnt;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)            ones_cnt <= 3'd0;
    else if (!tms)          ones_cnt <= 3'd0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  // R1
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (state == TS_RESET));

endmodule

// File: rtl/jtag_bscan_cell.sv
module jtag_bscan_cell
  import jtag_bscan_pkg::*;
#(
  parameter int KIND = PK_BIDIR
) (
  input  logic tck,
  input  logic trst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic extest,
  input  logic si,
  output logic so,
  input  logic core_o,
  input  logic core_oe,
  output logic core_i,
  input  logic pad_i,
  output logic pad_o,
  output logic pad_oe
);

  localparam int HAS_IN  = (KIND == PK_IN  || KIND == PK_BIDIR) ? 1 : 0;
  localparam int HAS_OUT = (KIND != PK_IN) ? 1 : 0;
  localparam int HAS_OE  = (KIND == PK_TRI || KIND == PK_BIDIR) ? 1 : 0;
  localparam int W       = HAS_IN + HAS_OUT + HAS_OE;
  localparam int OUT_IX  = HAS_IN;
  localparam int OE_IX   = HAS_IN + HAS_OUT;

  // field 0 sits nearest the TDI end of the cell
  logic [W-1:0] sh_q, hd_q, cap;
  logic [W:0]   sh_ext;

  assign sh_ext = {sh_q, si};
  assign so     = sh_q[W-1];

  generate
    if (HAS_IN != 0) begin : g_in
      assign cap[0] = pad_i;
      assign core_i = pad_i;
    end else begin : g_no_in
      assign core_i = 1'b0;
    end

    if (HAS_OUT != 0) begin : g_out
      assign cap[OUT_IX] = core_o;
      assign pad_o       = extest ? hd_q[OUT_IX] : core_o;
    end else begin : g_no_out
      assign pad_o = 1'b0;
    end

    if (HAS_OE != 0) begin : g_oe
      assign cap[OE_IX] = core_oe;
      assign pad_oe     = extest ? hd_q[OE_IX] : core_oe;
    end else if (HAS_OUT != 0) begin : g_fixed_oe
      assign pad_oe = 1'b1;
    end else begin : g_no_oe
      assign pad_oe = 1'b0;
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       sh_q <= '0;
    else if (cap_en)   sh_q <= cap;
    else if (shift_en) sh_q <= sh_ext[W-1:0];
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     hd_q <= '0;
    else if (upd_en) hd_q <= sh_q;
  end

  logic unused_sink;
  assign unused_sink = ^{core_o, core_oe, pad_i, hd_q};

  // R9
  hold_stable_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !upd_en |=> $stable(hd_q));

endmodule

// File: rtl/jtag_bscan_tap.sv
module jtag_bscan_tap
  import jtag_bscan_pkg::*;
#(
  parameter int                    NUM_PADS  = 4,
  parameter logic [2*NUM_PADS-1:0] PAD_KINDS = 8'b11_10_01_00,
  parameter logic [31:0]           ID_VALUE  = 32'h0000_18FF,
  parameter int                    TEST_W    = 3
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                tms,
  input  logic                tdi,
  output logic                tdo,
  output logic                tdo_oe,
  input  logic [NUM_PADS-1:0] core_o,
  input  logic [NUM_PADS-1:0] core_oe,
  output logic [NUM_PADS-1:0] core_i,
  input  logic [NUM_PADS-1:0] pad_i,
  output logic [NUM_PADS-1:0] pad_o,
  output logic [NUM_PADS-1:0] pad_oe
);

  localparam int ID_W = 32;

  tap_state_e state;

  jtag_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  logic in_reset, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
  assign in_reset = (state == TS_RESET);
  assign cap_dr   = (state == TS_CAP_DR);
  assign sh_dr    = (state == TS_SHIFT_DR);
  assign upd_dr   = (state == TS_UPD_DR);
  assign cap_ir   = (state == TS_CAP_IR);
  assign sh_ir    = (state == TS_SHIFT_IR);
  assign upd_ir   = (state == TS_UPD_IR);

  // instruction register: shift stage and active stage
  logic [OP_W-1:0] ir_sr, ir_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     ir_sr <= '0;
    else if (cap_ir) ir_sr <= IR_CAPTURE;
    else if (sh_ir)  ir_sr <= {tdi, ir_sr[OP_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       ir_q <= OP_IDCODE;
    else if (in_reset) ir_q <= OP_IDCODE;
    else if (upd_ir)   ir_q <= ir_sr;
  end

  logic sel_bsr, sel_id, sel_test, sel_byp, extest;
  assign extest   = (ir_q == OP_EXTEST);
  assign sel_bsr  = extest || (ir_q == OP_SAMPLE);
  assign sel_id   = (ir_q == OP_IDCODE);
  assign sel_test = (ir_q == OP_TESTREG);
  assign sel_byp  = !(sel_bsr || sel_id || sel_test);

  // identification register
  logic [ID_W-1:0] id_sr;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)               id_sr <= '0;
    else if (cap_dr && sel_id) id_sr <= ID_VALUE;
    else if (sh_dr && sel_id)  id_sr <= {tdi, id_sr[ID_W-1:1]};
  end

  // general test register: capture keeps its contents
  logic [TEST_W-1:0] test_q;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                test_q <= '0;
    else if (sh_dr && sel_test) test_q <= {tdi, test_q[TEST_W-1:1]};
  end

  // bypass register
  logic byp_q;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                byp_q <= 1'b0;
    else if (cap_dr && sel_byp) byp_q <= 1'b0;
    else if (sh_dr && sel_byp)  byp_q <= tdi;
  end

  // boundary chain, pad 0 nearest TDI
  logic [NUM_PADS:0] link;
  assign link[0] = tdi;

  generate
    for (genvar k = 0; k < NUM_PADS; k++) begin : g_pad
      jtag_bscan_cell #(.KIND(int'(PAD_KINDS[2*k +: 2]))) u_cell (
        .tck      (tck),
        .trst_n   (trst_n),
        .cap_en   (cap_dr && sel_bsr),
        .shift_en (sh_dr && sel_bsr),
        .upd_en   (upd_dr && sel_bsr),
        .extest   (extest),
        .si       (link[k]),
        .so       (link[k+1]),
        .core_o   (core_o[k]),
        .core_oe  (core_oe[k]),
        .core_i   (core_i[k]),
        .pad_i    (pad_i[k]),
        .pad_o    (pad_o[k]),
        .pad_oe   (pad_oe[k])
      );
    end
  endgenerate

  logic dr_bit;
  always_comb begin
    if (sel_bsr)       dr_bit = link[NUM_PADS];
    else if (sel_id)   dr_bit = id_sr[0];
    else if (sel_test) dr_bit = test_q[0];
    else               dr_bit = byp_q;
  end

  // TDO launched on the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= sh_ir || sh_dr;
      tdo    <= sh_ir ? ir_sr[0] : (sh_dr ? dr_bit : 1'b0);
    end
  end

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAP_IR) |=> (ir_sr == IR_CAPTURE));

  // R2
  reset_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET) |=> (ir_q == OP_IDCODE));

  // R5
  bypass_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAP_DR && sel_byp) |=> !byp_q);

  // R11
  tdo_window_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == TS_SHIFT_IR || state == TS_SHIFT_DR));

endmodule

// File: tb/test_jtag_bscan_tap.sv
module test_jtag_bscan_tap;

  localparam int TCK_PERIOD = 20;
  localparam int NP = 4;

  logic tck = 1'b0;
  logic trst_n, tms, tdi;
  logic tdo, tdo_oe;
  logic [NP-1:0] core_o, core_oe, core_i, pad_i, pad_o, pad_oe;

  always #(TCK_PERIOD/2) tck = ~tck;

  jtag_bscan_tap i_jtag_bscan_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe),
    .core_o(core_o), .core_oe(core_oe), .core_i(core_i),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  // scoreboard
  typedef struct {
    string       req;
    logic [63:0] act;
    logic [63:0] exp;
  } item_t;
  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic push(input string req, input logic [63:0] act, input logic [63:0] exp);
    item_t it;
    it.req = req; it.act = act; it.exp = exp;
    sb_q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge tck);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (it.act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%0h expected=%0h", it.req, it.act, it.exp);
        end
      end
    end
  end

  // reference model of the default layout
  function automatic logic [6:0] cap_word(input logic [3:0] pi, input logic [3:0] co, input logic [3:0] coe);
    return {pi[0], co[1], co[2], coe[2], pi[3], co[3], coe[3]};
  endfunction

  function automatic logic [3:0] exp_pad_o(input bit ext, input logic [6:0] h, input logic [3:0] co);
    if (ext) return {h[1], h[4], h[5], 1'b0};
    return {co[3], co[2], co[1], 1'b0};
  endfunction

  function automatic logic [3:0] exp_pad_oe(input bit ext, input logic [6:0] h, input logic [3:0] coe);
    if (ext) return {h[0], h[3], 1'b1, 1'b0};
    return {coe[3], coe[2], 1'b1, 1'b0};
  endfunction

  logic last_tdo, last_oe, last_post;

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    #(TCK_PERIOD/2 - 4);
    last_tdo = tdo;
    last_oe  = tdo_oe;
    @(posedge tck);
    #1;
    last_post = tdo;
  endtask

  task automatic scan_ir(input logic [3:0] code, output logic [3:0] dout);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i]);
      dout[i] = last_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input bit via_pause,
                         output logic [63:0] dout, output bit hold_ok, output bit oe_ok);
    dout = '0; hold_ok = 1; oe_ok = 1;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = last_tdo;
      if (last_oe !== 1'b1) oe_ok = 0;
      if (last_post !== last_tdo) hold_ok = 0;
    end
    if (via_pause) begin
      step(0, 0); step(0, 0); step(1, 0); step(1, 0); step(0, 0);
    end else begin
      step(1, 0); step(0, 0);
    end
  endtask

  initial begin
    #(TCK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [3:0]  irv;
    bit hok, ook;
    logic [6:0] h1, h2;

    trst_n = 0; tms = 1; tdi = 0;
    core_o = 4'b0000; core_oe = 4'b0000; pad_i = 4'b0000;
    repeat (3) @(negedge tck);
    #1 trst_n = 1;

    // R2 reset state, functional pads
    core_o = 4'b0100; core_oe = 4'b1100; pad_i = 4'b0001;
    step(0, 0);
    push("R2 tdo_oe idle", 64'(tdo_oe), 64'd0);
    push("R2 pad_o functional", 64'(pad_o), 64'(exp_pad_o(0, 7'd0, core_o)));
    push("R9 pad_oe functional", 64'(pad_oe), 64'(exp_pad_oe(0, 7'd0, core_oe)));

    // R4 IDCODE, R11 timing
    scan_dr(32, 64'h0, 0, d, hok, ook);
    push("R4 idcode", d, 64'h18FF);
    push("R11 tdo holds through rising edge", 64'(hok), 64'd1);
    push("R11 tdo_oe in shift", 64'(ook), 64'd1);
    push("R11 tdo_oe after shift", 64'(tdo_oe), 64'd0);

    // R3 capture pattern
    scan_ir(4'd2, irv);
    push("R3 ir capture", 64'(irv), 64'b0001);

    // R8 sample, R9 preload leaves pads
    h1 = 7'b0100110;
    scan_dr(7, 64'(h1), 0, d, hok, ook);
    push("R8 sample capture", d, 64'(cap_word(pad_i, core_o, core_oe)));
    push("R9 preload pad_o", 64'(pad_o), 64'(exp_pad_o(0, h1, core_o)));
    push("R9 preload pad_oe", 64'(pad_oe), 64'(exp_pad_oe(0, h1, core_oe)));
    push("R12 core_i sample", 64'(core_i), 64'(pad_i & 4'b1001));

    // R10 external test from preloaded hold
    scan_ir(4'd0, irv);
    push("R10 extest pad_o", 64'(pad_o), 64'(exp_pad_o(1, h1, core_o)));
    push("R10 extest pad_oe", 64'(pad_oe), 64'(exp_pad_oe(1, h1, core_oe)));

    // R10 core changes ignored, R12 core_i follows pad_i
    core_o = 4'b1110; core_oe = 4'b0000; pad_i = 4'b1000;
    step(0, 0);
    push("R10 core ignored pad_o", 64'(pad_o), 64'(exp_pad_o(1, h1, 4'b0100)));
    push("R10 core ignored pad_oe", 64'(pad_oe), 64'(exp_pad_oe(1, h1, 4'b1100)));
    push("R12 core_i extest", 64'(core_i), 64'(pad_i & 4'b1001));

    // R7/R8 capture under extest, R1 update via pause
    h2 = 7'b1011010;
    scan_dr(7, 64'(h2), 1, d, hok, ook);
    push("R7 extest capture layout", d, 64'(cap_word(pad_i, core_o, core_oe)));
    push("R1 pause path pad_o", 64'(pad_o), 64'(exp_pad_o(1, h2, core_o)));
    push("R1 pause path pad_oe", 64'(pad_oe), 64'(exp_pad_oe(1, h2, core_oe)));

    // R1 five TMS high
    step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(0, 0);
    push("R1 tms reset pad_o", 64'(pad_o), 64'(exp_pad_o(0, h2, core_o)));
    scan_dr(32, 64'h0, 0, d, hok, ook);
    push("R1 idcode after tms reset", d, 64'h18FF);

    // R6 test register
    scan_ir(4'd4, irv);
    scan_dr(3, 64'b101, 0, d, hok, ook);
    push("R6 first scan", d, 64'd0);
    scan_dr(3, 64'b011, 0, d, hok, ook);
    push("R6 readback", d, 64'b101);

    // R5 bypass on two unused codes
    scan_ir(4'hF, irv);
    scan_dr(8, 64'hB5, 0, d, hok, ook);
    push("R5 bypass code 15", d, 64'h6A);
    scan_ir(4'h3, irv);
    scan_dr(8, 64'h4C, 0, d, hok, ook);
    push("R5 bypass code 3", d, 64'h98);

    // R2 asynchronous reset during external test
    scan_ir(4'd0, irv);
    scan_dr(7, 64'h7F, 0, d, hok, ook);
    push("R10 extest all ones pad_oe", 64'(pad_oe), 64'(exp_pad_oe(1, 7'h7F, core_oe)));
    @(negedge tck); #3 trst_n = 0;
    #2;
    push("R2 trst pad_o", 64'(pad_o), 64'(exp_pad_o(0, 7'h0, core_o)));
    push("R2 trst pad_oe", 64'(pad_oe), 64'(exp_pad_oe(0, 7'h0, core_oe)));
    @(negedge tck); #1 trst_n = 1;
    step(0, 0);
    scan_dr(32, 64'h0, 0, d, hok, ook);
    push("R2 idcode after trst", d, 64'h18FF);

    repeat (3) @(negedge tck);
    #1;
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule